// File: doc/BRIEF.md
# Four-Phase Link Presence Check

This block confirms that a host on the far side of a slow, software-driven link is present and answering before any data moves. The host arms it with a rising edge on the trigger input while holding the mode input low, which selects the write path. From then on the block only polls its inputs. Each input first passes through a synchronizer.

Once armed, the block runs a fixed series of four-phase request/acknowledge cycles. The host raises its request and the block pulls acknowledge low. The host drops its request and the block drives acknowledge high again. A per-phase timeout bounds every wait for the host, and the timer restarts at each phase. If the whole series completes, the block emits a one-cycle pass pulse. If any wait expires, it emits a one-cycle fail pulse. In both cases it releases acknowledge high and returns to idle.

Top module: `link_probe`

## Requirements
- R1: Out of reset, ack_o is high and pass_o and fail_o are low.
- R2: A rising edge on trig_i while mode_i is low starts a check. Acknowledge stays high until the host raises req_i.
- R3: A trigger edge while mode_i is high starts nothing. Afterwards, toggling req_i leaves ack_o high, and neither pass_o nor fail_o pulses.
- R4: During a check, ack_o goes low only after req_i has been seen high. It returns high only after req_i has been seen low, or on a failure. Each response appears within a few clock cycles of the input change.
- R5: pass_o pulses once, together with the final rise of ack_o, after exactly CYCLES complete cycles (50 by default). After fewer cycles there is no pass.
- R6: If req_i stays low for TIMEOUT clock cycles while the block waits for it to rise, fail_o pulses and ack_o stays high.
- R7: If req_i stays high for TIMEOUT clock cycles while ack_o is low, fail_o pulses and ack_o returns high in the same cycle.
- R8: pass_o and fail_o last one cycle each and are never high together. Afterwards the block is idle: req_i activity has no effect until a new trigger edge arrives.
- R9: The timeout counts per phase. A host that answers every phase just inside TIMEOUT still passes, even though the whole check lasts far longer than TIMEOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Start request; the rising edge counts (asynchronous) |
| mode_i | input | 1 | Path select; low selects the write path (asynchronous) |
| req_i | input | 1 | Host request line (asynchronous) |
| ack_o | output | 1 | Acknowledge to host, idles high |
| pass_o | output | 1 | One-cycle pulse: link verified |
| fail_o | output | 1 | One-cycle pulse: a host wait timed out |

## Verification
Full checks are run against a host model whose response delay in every phase is drawn at random. This shows that response timing alone never changes the outcome. Checks that stall after a random number of cycles below the required count must end in failure, which separates an exact count from any looser one. Directed stalls with the request held low, and with it held high, separate the two timeout phases. A host that answers every phase just before the limit shows that the timer restarts per phase and does not span the whole check. Triggers with mode high, and request toggles after a result, show that the block ignores the host when it is not armed.

// File: rtl/lp_pkg.sv
package lp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_HI = 2'd1,
        ST_WAIT_LO = 2'd2
    } lp_state_e;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lp_timer.sv
module lp_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                         cnt_d = '0;
        else if (cnt_q != CW'(LIMIT - 1))  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/lp_count.sv
module lp_count #(
    parameter int N = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(N - 1));
endmodule

// File: rtl/link_probe.sv
module link_probe
    import lp_pkg::*;
#(
    parameter int CYCLES      = 50,
    parameter int TIMEOUT     = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic mode_i,
    input  logic req_i,
    output logic ack_o,
    output logic pass_o,
    output logic fail_o
);
    typedef struct packed {
        lp_state_e state;
        logic      trig_prev;
        logic      ack;
        logic      pass;
        logic      fail;
    } lp_regs_t;

    localparam lp_regs_t REGS_RST = '{state: ST_IDLE, trig_prev: 1'b0,
                                      ack: 1'b1, pass: 1'b0, fail: 1'b0};

    lp_regs_t r_d, r_q;
    logic     trig_s, mode_s, req_s;
    logic     trig_edge, busy;
    logic     tmr_clr, tmr_exp;
    logic     cnt_clr, cnt_inc, cnt_last;

    lp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({trig_i, mode_i, req_i}),
        .q_o   ({trig_s, mode_s, req_s})
    );

    lp_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .expired_o (tmr_exp)
    );

    lp_count #(.N(CYCLES)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .last_o (cnt_last)
    );

    assign trig_edge = trig_s & ~r_q.trig_prev;
    assign busy      = (r_q.state != ST_IDLE);

    always_comb begin
        r_d           = r_q;
        r_d.trig_prev = trig_s;
        r_d.pass      = 1'b0;
        r_d.fail      = 1'b0;
        cnt_clr       = 1'b0;
        cnt_inc       = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.ack = 1'b1;
                if (trig_edge && !mode_s) begin
                    r_d.state = ST_WAIT_HI;
                    cnt_clr   = 1'b1;
                end
            end
            ST_WAIT_HI: begin
                if (req_s) begin
                    r_d.ack   = 1'b0;
                    r_d.state = ST_WAIT_LO;
                end else if (tmr_exp) begin
                    r_d.fail  = 1'b1;
                    r_d.ack   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_WAIT_LO: begin
                if (!req_s) begin
                    r_d.ack = 1'b1;
                    if (cnt_last) begin
                        r_d.pass  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        cnt_inc   = 1'b1;
                        r_d.state = ST_WAIT_HI;
                    end
                end else if (tmr_exp) begin
                    r_d.fail  = 1'b1;
                    r_d.ack   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d = REGS_RST;
        endcase
        tmr_clr = (r_q.state == ST_IDLE) || (r_d.state != r_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign ack_o  = r_q.ack;
    assign pass_o = r_q.pass;
    assign fail_o = r_q.fail;
endmodule

// File: rtl/link_probe_chk.sv
module link_probe_chk #(
    parameter int CYCLES  = 50,
    parameter int TIMEOUT = 100000
) (
    input logic clk,
    input logic rst_n,
    input logic req_s,
    input logic busy,
    input logic ack_o,
    input logic pass_o,
    input logic fail_o
);
    logic        ack_prev_q;
    logic [15:0] falls_q;
    logic [31:0] stall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_prev_q <= 1'b1;
            falls_q    <= '0;
            stall_q    <= '0;
        end else begin
            ack_prev_q <= ack_o;
            if (pass_o || fail_o)            falls_q <= '0;
            else if (ack_prev_q && !ack_o)   falls_q <= falls_q + 16'd1;
            if (busy && (ack_o == ack_prev_q)) stall_q <= stall_q + 32'd1;
            else                             stall_q <= '0;
        end
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));
    p_pass_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |=> !pass_o);
    p_fail_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);
    p_fall_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(req_s));
    p_rise_after_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_o) && !fail_o) |-> !$past(req_s));
    p_fail_ack_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> ack_o);
    p_pass_with_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> $rose(ack_o));
    p_pass_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (falls_q == 16'(CYCLES)));
    p_phase_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q <= 32'(TIMEOUT + 2));
endmodule

bind link_probe link_probe_chk #(.CYCLES(CYCLES), .TIMEOUT(TIMEOUT)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_s  (req_s),
    .busy   (busy),
    .ack_o  (ack_o),
    .pass_o (pass_o),
    .fail_o (fail_o)
);

// File: tb/link_probe_tb.sv
module link_probe_tb;
    localparam int CYC = 50;
    localparam int TO  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0, mode = 1'b1, req = 1'b0;
    logic ack, pass_p, fail_p;
    int   checks = 0, failures = 0;
    int   pass_cnt = 0, fail_cnt = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    link_probe #(.CYCLES(CYC), .TIMEOUT(TO), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .mode_i(mode), .req_i(req),
        .ack_o(ack), .pass_o(pass_p), .fail_o(fail_p)
    );

    always @(negedge clk) if (rst_n) begin
        if (pass_p) pass_cnt++;
        if (fail_p) fail_cnt++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // expected outcome of a check: pass only when every cycle completes
    function automatic int exp_pass(input bit m, input int k);
        return (!m && k == CYC) ? 1 : 0;
    endfunction
    function automatic int exp_fail(input bit m, input int k);
        return (!m && k < CYC) ? 1 : 0;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input bit m);
        mode = m; cyc(4);
        trig = 1'b1; cyc(4);
        trig = 1'b0;
    endtask

    task automatic wait_ack(input logic val, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge clk);
            if (ack === val) seen = 1'b1;
        end
    endtask

    // one host handshake cycle; R4 response checks
    task automatic host_cycle(input int dhi, input int dlo);
        bit s;
        cyc(dhi); req = 1'b1;
        wait_ack(1'b0, s);
        check(s, "R4 ack low after req high", ack, 0);
        cyc(dlo); req = 1'b0;
        wait_ack(1'b1, s);
        check(s, "R4 ack high after req low", ack, 1);
    endtask

    // R3/R8: host activity while idle leaves ack high, no pulses
    task automatic probe_idle(input string tag);
        int p0 = pass_cnt, f0 = fail_cnt;
        req = 1'b1; cyc(8);
        check(ack === 1'b1, tag, ack, 1);
        req = 1'b0; cyc(8);
        check(pass_cnt == p0 && fail_cnt == f0, tag, pass_cnt + fail_cnt - p0 - f0, 0);
    endtask

    task automatic session(input bit m, input int k, input int dmax);
        int p0 = pass_cnt, f0 = fail_cnt;
        arm(m);
        if (m) begin
            probe_idle("R3 mode high ignored");
        end else begin
            for (int i = 0; i < k; i++)
                host_cycle($urandom_range(dmax), $urandom_range(dmax));
            if (k < CYC) cyc(TO + 10); else cyc(4);
        end
        check(pass_cnt - p0 == exp_pass(m, k), "R5 pass count", pass_cnt - p0, exp_pass(m, k));
        check(fail_cnt - f0 == exp_fail(m, k), "R6 fail count", fail_cnt - f0, exp_fail(m, k));
        check(ack === 1'b1, "R8 ack idle after check", ack, 1);
    endtask

    initial begin
        cyc(2000 * 100);
        checks++; failures++;
        $display("FAIL watchdog expired R5");
        report();
    end

    initial begin
        int f0;
        bit s;
        void'($urandom(32'd20240611));
        cyc(3);
        check(ack === 1'b1 && pass_p === 1'b0 && fail_p === 1'b0, "R1 reset state",
              {ack, pass_p, fail_p}, 3'b100);
        rst_n = 1'b1; cyc(3);
        check(ack === 1'b1, "R1 ack idle after reset", ack, 1);

        // R2: started, waits for req with ack high
        arm(1'b0); cyc(4);
        check(ack === 1'b1 && fail_cnt == 0, "R2 waiting with ack high", ack, 1);
        for (int i = 0; i < CYC; i++) host_cycle(2, 1);
        cyc(4);
        check(pass_cnt == 1, "R5 directed pass", pass_cnt, 1);
        probe_idle("R8 idle after pass");

        // R6: no request at all
        f0 = fail_cnt;
        arm(1'b0); cyc(TO - 12);
        check(fail_cnt == f0, "R6 no early fail", fail_cnt - f0, 0);
        cyc(24);
        check(fail_cnt - f0 == 1, "R6 timeout waiting for req high", fail_cnt - f0, 1);
        check(ack === 1'b1, "R6 ack stays high", ack, 1);

        // R7: request held high
        f0 = fail_cnt;
        arm(1'b0); req = 1'b1;
        wait_ack(1'b0, s);
        check(s, "R7 ack low before stall", ack, 0);
        cyc(TO + 10);
        check(fail_cnt - f0 == 1, "R7 timeout waiting for req low", fail_cnt - f0, 1);
        check(ack === 1'b1, "R7 ack back high", ack, 1);
        probe_idle("R8 idle after fail");
        req = 1'b0; cyc(4);

        // R5: one short of the count
        session(1'b0, CYC - 1, 3);

        // R9: every phase close to the limit
        arm(1'b0);
        for (int i = 0; i < CYC; i++) host_cycle(TO - 14, TO - 14);
        cyc(4);
        check(pass_cnt == 2, "R9 slow host passes", pass_cnt, 2);

        // random sessions
        for (int n = 0; n < 12; n++) begin
            bit m = ($urandom_range(3) == 0);
            int k = ($urandom_range(2) == 0) ? $urandom_range(CYC - 1) : CYC;
            session(m, k, TO - 14);
        end
        session(1'b1, CYC, 0);
        report();
    end
endmodule